// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

A 4096-bit on-chip memory with one port that only writes and one port that only reads. Each port runs on its own clock, with its own clock enable and its own clear. The two ports may have different widths: one side is always 1 bit wide, and the other side is 1, 2, 4, 8 or 16 bits wide. This makes the block a natural serialiser or deserialiser buffer. For example, a bit stream can be stored one bit per cycle and then collected as 16-bit words, or the reverse.

The read side can be built with or without an output register, chosen by parameter. It also has a read-enable input that a parameter can switch off, in which case every clock-enabled read cycle performs a read. The stored bits are never initialised or cleared. The clears act only on the port registers.

Top module: `mwdp_ram`

## Requirements
- R1: Capacity is MEM_BITS (default 4096) bits. Each port's depth is MEM_BITS divided by its width, so the widest legal address reaches the last stored bit (narrow address 4095, or word 255 at 16 bits).
- R2: Bit mapping: narrow address k is stored bit k. Word j of a W-bit port covers stored bits j*W up to j*W+W-1, and the lowest narrow address of that word sits in bit 0 of the word.
- R3: A write happens at a rising wr_clk edge only when wr_ce and wr_en are both 1 and wr_clr is 0. Any other combination leaves the contents unchanged, whatever wr_addr and wr_data hold.
- R4: With the output register (OUT_REG=1), a read issued at the same edge as a write to the same location returns the old contents. The following read returns the new value. Both ports act in the same cycle.
- R5: With OUT_REG=1, a rd_clk edge where rd_ce is 0, or where the read enable is 0, leaves rd_data unchanged.
- R6: With HAS_RDEN=0, the rd_en input is ignored, and every rd_clk edge with rd_ce=1 performs a read.
- R7: Without the output register (OUT_REG=0), rd_data follows the current contents at the last latched read address. A write at the same edge as the read is therefore visible within that clock period, and a later write to that location changes rd_data without a new read.
- R8: rd_clr is an asynchronous active-high clear. It sets the latched read address and the output register to zero (rd_data reads 0 with OUT_REG=1) and does not alter the stored bits.
- R9: While wr_clr is 1, no write takes place and the stored bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_clr | input | 1 | Write-side clear, active high; blocks writes |
| wr_ce | input | 1 | Write-side clock enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | WA_W | Write address in write-port words |
| wr_data | input | WR_W | Write data |
| rd_clk | input | 1 | Read-side clock |
| rd_clr | input | 1 | Read-side asynchronous clear, active high |
| rd_ce | input | 1 | Read-side clock enable |
| rd_en | input | 1 | Read enable (ignored when HAS_RDEN=0) |
| rd_addr | input | RA_W | Read address in read-port words |
| rd_data | output | RD_W | Read data |

## Verification
Two configurations are exercised from one clock.

The first writes 1 bit at a time and reads 16-bit registered words. A set of word patterns is written bit by bit and read back. The patterns are a lone low bit, a lone top bit at the last word, an irregular mix, all ones and a half-filled word. Together they separate a correct bit order from a reversed or shifted mapping and reveal an address that stops short of the top of the array.

The second configuration writes 16-bit words and reads single bits with no output register and with the read enable disabled. It reads the low, middle and top bit of each pattern, which checks the same mapping from the other side.

Directed cases cover the following:
- old data on a same-edge read versus new data on the unregistered path;
- output hold with the read enable low and with the clock enable low;
- writes blocked by the write enable, the clock enable and the write clear;
- a read clear that zeroes the output without disturbing the contents.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    // Number of words a port of width w sees in a memory of total bits.
    function automatic int unsigned words_for(int unsigned total, int unsigned w);
        return total / w;
    endfunction

    // Address width for a given depth, never below one bit.
    function automatic int unsigned addr_bits(int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/mwram_store.sv
module mwram_store #(
    parameter int unsigned MEM_BITS = 4096,
    parameter int unsigned WR_W     = 1,
    parameter int unsigned WA_W     = 12
) (
    input  logic                wr_clk,
    input  logic                wr_clr,
    input  logic                wr_ce,
    input  logic                wr_en,
    input  logic [WA_W-1:0]     wr_addr,
    input  logic [WR_W-1:0]     wr_data,
    output logic [MEM_BITS-1:0] mem
);
    localparam int unsigned MA_W = mwram_pkg::addr_bits(MEM_BITS);
    localparam int unsigned SH   = $clog2(WR_W);

    typedef struct packed {
        logic [MEM_BITS-1:0] bits;
    } store_t;

    store_t          st_d, st_q;
    logic            wr_go;
    logic [MA_W-1:0] wr_base;

    assign wr_go   = wr_ce && wr_en && !wr_clr;
    assign wr_base = MA_W'(wr_addr) << SH;

    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            st_d.bits[wr_base +: WR_W] = wr_data;
        end
    end

    // Contents carry no reset: clears act on port registers only.
    always_ff @(posedge wr_clk) begin
        st_q <= st_d;
    end

    assign mem = st_q.bits;

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge wr_clk) disable iff (wr_clr)
        !(wr_ce && wr_en) |=> $stable(mem)); // R3
    AST_CLR_KEEPS_DATA: assert property (@(posedge wr_clk)
        wr_clr |=> $stable(mem)); // R9

endmodule

// File: rtl/mwram_rd.sv
module mwram_rd #(
    parameter int unsigned MEM_BITS = 4096,
    parameter int unsigned RD_W     = 16,
    parameter int unsigned RA_W     = 8,
    parameter bit          OUT_REG  = 1'b1,
    parameter bit          HAS_RDEN = 1'b1
) (
    input  logic                rd_clk,
    input  logic                rd_clr,
    input  logic                rd_ce,
    input  logic                rd_en,
    input  logic [RA_W-1:0]     rd_addr,
    input  logic [MEM_BITS-1:0] mem,
    output logic [RD_W-1:0]     rd_data
);
    localparam int unsigned MA_W = mwram_pkg::addr_bits(MEM_BITS);
    localparam int unsigned SH   = $clog2(RD_W);

    typedef struct packed {
        logic [RA_W-1:0] addr;
        logic [RD_W-1:0] dout;
    } rd_state_t;

    rd_state_t       r_d, r_q;
    logic            en_eff;
    logic            rd_go;
    logic [MA_W-1:0] base_in;
    logic [MA_W-1:0] base_q;

    assign en_eff  = HAS_RDEN ? rd_en : 1'b1;
    assign rd_go   = rd_ce && en_eff;
    assign base_in = MA_W'(rd_addr) << SH;
    assign base_q  = MA_W'(r_q.addr) << SH;

    always_comb begin
        r_d = r_q;
        if (rd_go) begin
            r_d.addr = rd_addr;
            r_d.dout = mem[base_in +: RD_W];
        end
    end

    always_ff @(posedge rd_clk or posedge rd_clr) begin
        if (rd_clr) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (OUT_REG) begin
            rd_data = r_q.dout;
        end else begin
            rd_data = mem[base_q +: RD_W];
        end
    end

    AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (rd_clr)
        (OUT_REG && !(rd_ce && en_eff)) |=> $stable(rd_data)); // R5
    AST_RD_CLR_ZERO: assert property (@(posedge rd_clk)
        rd_clr |-> (r_q.addr == '0 && r_q.dout == '0)); // R8
    AST_RDEN_IGNORED: assert property (@(posedge rd_clk) disable iff (rd_clr)
        (!HAS_RDEN && rd_ce) |=> (r_q.addr == $past(rd_addr))); // R6

endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram #(
    parameter int unsigned MEM_BITS = 4096,
    parameter int unsigned WR_W     = 1,
    parameter int unsigned RD_W     = 16,
    parameter bit          OUT_REG  = 1'b1,
    parameter bit          HAS_RDEN = 1'b1,
    localparam int unsigned WA_W = mwram_pkg::addr_bits(mwram_pkg::words_for(MEM_BITS, WR_W)),
    localparam int unsigned RA_W = mwram_pkg::addr_bits(mwram_pkg::words_for(MEM_BITS, RD_W))
) (
    input  logic            wr_clk,
    input  logic            wr_clr,
    input  logic            wr_ce,
    input  logic            wr_en,
    input  logic [WA_W-1:0] wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_clk,
    input  logic            rd_clr,
    input  logic            rd_ce,
    input  logic            rd_en,
    input  logic [RA_W-1:0] rd_addr,
    output logic [RD_W-1:0] rd_data
);
    logic [MEM_BITS-1:0] mem_bits;

    mwram_store #(
        .MEM_BITS (MEM_BITS),
        .WR_W     (WR_W),
        .WA_W     (WA_W)
    ) u_store (
        .wr_clk  (wr_clk),
        .wr_clr  (wr_clr),
        .wr_ce   (wr_ce),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mem     (mem_bits)
    );

    mwram_rd #(
        .MEM_BITS (MEM_BITS),
        .RD_W     (RD_W),
        .RA_W     (RA_W),
        .OUT_REG  (OUT_REG),
        .HAS_RDEN (HAS_RDEN)
    ) u_rd (
        .rd_clk  (rd_clk),
        .rd_clr  (rd_clr),
        .rd_ce   (rd_ce),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .mem     (mem_bits),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_mwdp_ram.sv
module test_mwdp_ram;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Configuration A: 1-bit write, 16-bit registered read with read enable.
    logic        a_wr_clr = 1'b1, a_wr_ce = 1'b0, a_wr_en = 1'b0;
    logic [11:0] a_wr_addr = '0;
    logic [0:0]  a_wr_data = '0;
    logic        a_rd_clr = 1'b1, a_rd_ce = 1'b0, a_rd_en = 1'b0;
    logic [7:0]  a_rd_addr = '0;
    logic [15:0] a_rd_data;

    // Configuration B: 16-bit write, 1-bit unregistered read, read enable off.
    logic        b_wr_clr = 1'b1, b_wr_ce = 1'b0, b_wr_en = 1'b0;
    logic [7:0]  b_wr_addr = '0;
    logic [15:0] b_wr_data = '0;
    logic        b_rd_clr = 1'b1, b_rd_ce = 1'b0, b_rd_en = 1'b0;
    logic [11:0] b_rd_addr = '0;
    logic [0:0]  b_rd_data;

    mwdp_ram #(.WR_W(1), .RD_W(16), .OUT_REG(1'b1), .HAS_RDEN(1'b1)) i_mwdp_ram (
        .wr_clk(clk), .wr_clr(a_wr_clr), .wr_ce(a_wr_ce), .wr_en(a_wr_en),
        .wr_addr(a_wr_addr), .wr_data(a_wr_data),
        .rd_clk(clk), .rd_clr(a_rd_clr), .rd_ce(a_rd_ce), .rd_en(a_rd_en),
        .rd_addr(a_rd_addr), .rd_data(a_rd_data)
    );

    mwdp_ram #(.WR_W(16), .RD_W(1), .OUT_REG(1'b0), .HAS_RDEN(1'b0)) i_mwdp_ram_b (
        .wr_clk(clk), .wr_clr(b_wr_clr), .wr_ce(b_wr_ce), .wr_en(b_wr_en),
        .wr_addr(b_wr_addr), .wr_data(b_wr_data),
        .rd_clk(clk), .rd_clr(b_rd_clr), .rd_ce(b_rd_ce), .rd_en(b_rd_en),
        .rd_addr(b_rd_addr), .rd_data(b_rd_data)
    );

    // {word index, 16-bit pattern}
    localparam logic [23:0] VEC [5] = '{
        {8'd0,   16'h0001},
        {8'd255, 16'h8000},
        {8'd17,  16'hA5C3},
        {8'd100, 16'hFFFF},
        {8'd3,   16'h5A00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic a_wr_bit(input int addr, input logic v);
        a_wr_addr = 12'(addr); a_wr_data = v; a_wr_ce = 1'b1; a_wr_en = 1'b1;
        @(negedge clk);
        a_wr_ce = 1'b0; a_wr_en = 1'b0;
    endtask

    task automatic a_wr_word(input int j, input logic [15:0] pat);
        for (int i = 0; i < 16; i++) a_wr_bit(j * 16 + i, pat[i]);
    endtask

    task automatic a_read(input int j);
        a_rd_addr = 8'(j); a_rd_ce = 1'b1; a_rd_en = 1'b1;
        @(negedge clk);
        a_rd_ce = 1'b0; a_rd_en = 1'b0;
    endtask

    task automatic b_wr_word(input int j, input logic [15:0] pat);
        b_wr_addr = 8'(j); b_wr_data = pat; b_wr_ce = 1'b1; b_wr_en = 1'b1;
        @(negedge clk);
        b_wr_ce = 1'b0; b_wr_en = 1'b0;
    endtask

    task automatic b_read(input int k);
        b_rd_addr = 12'(k); b_rd_ce = 1'b1; b_rd_en = 1'b0;
        @(negedge clk);
        b_rd_ce = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: output register is zero while the read clear is held.
        check("R8 reset state", a_rd_data, 16'h0000);
        a_wr_clr = 1'b0; a_rd_clr = 1'b0; b_wr_clr = 1'b0; b_rd_clr = 1'b0;
        @(negedge clk);

        // Table walk: R1 (word 255 / bit 4095) and R2 (bit order) on both configurations.
        for (int v = 0; v < 5; v++) begin
            a_wr_word(int'(VEC[v][23:16]), VEC[v][15:0]);
            a_read(int'(VEC[v][23:16]));
            check("R1/R2 A word", a_rd_data, VEC[v][15:0]);
            b_wr_word(int'(VEC[v][23:16]), VEC[v][15:0]);
            for (int p = 0; p < 16; p += 7) begin
                // R6: rd_en held 0, read still performed.
                b_read(int'(VEC[v][23:16]) * 16 + p);
                check("R2/R6 B bit", 16'(b_rd_data), 16'(VEC[v][p]));
            end
            b_read(int'(VEC[v][23:16]) * 16 + 15);
            check("R1/R2 B top bit", 16'(b_rd_data), 16'(VEC[v][15]));
        end

        // R4: same-edge write and read on configuration A.
        a_wr_word(5, 16'h0000);
        a_wr_addr = 12'd80; a_wr_data = 1'b1; a_wr_ce = 1'b1; a_wr_en = 1'b1;
        a_rd_addr = 8'd5; a_rd_ce = 1'b1; a_rd_en = 1'b1;
        @(negedge clk);
        a_wr_ce = 1'b0; a_wr_en = 1'b0; a_rd_ce = 1'b0; a_rd_en = 1'b0;
        check("R4 same-edge old", a_rd_data, 16'h0000);
        a_read(5);
        check("R4 next read new", a_rd_data, 16'h0001);

        // R5: hold with read enable low, then with clock enable low.
        a_read(17);
        check("R5 setup", a_rd_data, 16'hA5C3);
        a_rd_addr = 8'd0; a_rd_ce = 1'b1; a_rd_en = 1'b0;
        @(negedge clk);
        check("R5 rd_en low", a_rd_data, 16'hA5C3);
        a_rd_ce = 1'b0; a_rd_en = 1'b1;
        @(negedge clk);
        a_rd_en = 1'b0;
        check("R5 rd_ce low", a_rd_data, 16'hA5C3);

        // R3: write enable low, then clock enable low: no change.
        a_wr_addr = 12'(17 * 16); a_wr_data = 1'b0; a_wr_ce = 1'b1; a_wr_en = 1'b0;
        @(negedge clk);
        a_wr_ce = 1'b0; a_wr_en = 1'b1;
        @(negedge clk);
        a_wr_en = 1'b0;
        a_read(17);
        check("R3 gated writes", a_rd_data, 16'hA5C3);

        // R9: write clear blocks an enabled write.
        a_wr_clr = 1'b1;
        a_wr_addr = 12'(17 * 16 + 1); a_wr_data = 1'b0; a_wr_ce = 1'b1; a_wr_en = 1'b1;
        @(negedge clk);
        a_wr_ce = 1'b0; a_wr_en = 1'b0; a_wr_clr = 1'b0;
        a_read(17);
        check("R9 write clear", a_rd_data, 16'hA5C3);

        // R8: asynchronous read clear zeroes output, contents kept.
        a_rd_clr = 1'b1;
        #1;
        check("R8 async clear", a_rd_data, 16'h0000);
        @(negedge clk);
        a_rd_clr = 1'b0;
        a_read(17);
        check("R8 contents kept", a_rd_data, 16'hA5C3);

        // R7: unregistered path shows same-edge write, and later writes without a read.
        b_wr_word(9, 16'h0000);
        b_wr_addr = 8'd9; b_wr_data = 16'hFFFF; b_wr_ce = 1'b1; b_wr_en = 1'b1;
        b_rd_addr = 12'(9 * 16 + 3); b_rd_ce = 1'b1;
        @(negedge clk);
        b_wr_ce = 1'b0; b_wr_en = 1'b0; b_rd_ce = 1'b0;
        check("R7 same-edge new", 16'(b_rd_data), 16'h0001);
        b_wr_word(9, 16'h0000);
        check("R7 follows contents", 16'(b_rd_data), 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule